// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital control front end of a four-channel, 8-bit analog-to-digital converter in a small microcontroller. Software uses one 8-bit control register, written as a whole byte or one bit at a time, to enable the converter, choose a channel and a conversion clock, and start a conversion. The register reports progress through two status bits: a start/busy bit and a done flag. The done flag also drives the interrupt request.

A conversion is timed in one of two ways. It can count machine-cycle strobes from the CPU domain. It can also hand the timing to a separate RC clock domain through a toggle synchroniser in each direction. When the conversion finishes, the 8-bit value from a behavioural converter stub for the selected channel is latched into a result register. While the converter is busy or holding an unread result, the register protects its configuration fields.

No data stream crosses the block's edge. The result is a level-held register that changes only when a conversion completes, so it needs no valid/ready handshake and applies no back-pressure. All control pins are plain.

Top module: `adc_ctrl_seq`

## Requirements
- R1: After reset the control register reads 0x00, the result reads 0x00 and irq is low.
- R2: Control register fields: bit 7 enable, bit 4 done, bit 3 start/busy, bit 2 RC clock select, bits 1:0 channel. Bits 6 and 5 always read 0, and writes to them are dropped. A byte write (wr_en) takes priority over a single-bit write (bit_wr_en writes bit_val to bit bit_idx).
- R3: A write of 1 to the start bit is accepted when start and done are both 0 and the enable bit is 1 after that same write. Start then reads 1 from the next cycle until the hardware clears it.
- R4: A write of 1 to the start bit while start or done reads 1 is ignored: nothing restarts and the completion time does not change.
- R5: Hardware sets the done bit at completion, and irq follows the done bit. Software clears done by writing 0 to it. Writing 1 to done has no effect.
- R6: The enable bit can be set at any time. A write that would clear it while start or done is 1 is discarded.
- R7: Writes to the RC-select and channel fields are discarded while start or done is 1.
- R8: With the CPU clock selected, done rises at the 31st machine-cycle strobe counted after the cycle in which the start was accepted.
- R9: Start and done both read 1 for exactly one machine cycle: start clears at the first machine-cycle strobe after done was set.
- R10: With the RC clock selected, done rises no earlier than 2 machine cycles plus 108 RC periods, and no later than 6 machine cycles plus 112 RC periods, after the start was accepted.
- R11: At completion the result captures input ain[8*c+7:8*c], where c is the channel code (00 to 11 selects input 0 to 3). The result then holds until the next completion.
- R12: A start write while enable is 0 after that write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mc_tick | input | 1 | One-clock machine-cycle strobe |
| rc_clk | input | 1 | Separate RC conversion clock |
| wr_en | input | 1 | Whole-byte register write |
| wr_data | input | 8 | Byte write data |
| bit_wr_en | input | 1 | Single-bit register write |
| bit_idx | input | 3 | Bit position for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| ain | input | 32 | Converter stub inputs, 8 bits per channel, channel 0 in the low byte |
| ctrl_q | output | 8 | Control register read value |
| irq | output | 1 | Conversion-complete interrupt request |
| result | output | 8 | Last conversion result |

## Verification
The bench runs conversions from the CPU-timed path and the RC-timed path. It uses both byte writes and single-bit writes, and sometimes sets enable in the same write as start, so that acceptance rules and timing sources are exercised separately. While a conversion is active, and while done is pending, the bench sends restart, disable and channel-change writes. These separate a protection rule that works from one that only looks right when nobody interferes. A write-1 to done and a change of the analog input after completion show that the flag and the latched result move only at completion. A behavioural model is compared against the register, irq and result on every clock. The RC-timed completion is accepted only inside its allowed time window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int B_EN    = 7;
  localparam int B_RSV1  = 6;
  localparam int B_RSV0  = 5;
  localparam int B_DONE  = 4;
  localparam int B_START = 3;
  localparam int B_RC    = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CONV = 2'd1,
    SQ_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_rc_timer.sv
module adc_rc_timer #(
  parameter int RC_CNT = 108
) (
  input  logic clk,
  input  logic rc_clk,
  input  logic rst_n,
  input  logic req_tgl,
  output logic ack_evt
);
  localparam int RW = (RC_CNT > 1) ? $clog2(RC_CNT) : 1;

  // RC domain: request synchroniser and period counter
  logic          rq_s1, rq_s2, rq_s3;
  logic          run;
  logic [RW-1:0] rcnt;
  logic          ack_tgl;
  logic          go;

  assign go = rq_s2 ^ rq_s3;

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_s1   <= 1'b0;
      rq_s2   <= 1'b0;
      rq_s3   <= 1'b0;
      run     <= 1'b0;
      rcnt    <= '0;
      ack_tgl <= 1'b0;
    end else begin
      rq_s1 <= req_tgl;
      rq_s2 <= rq_s1;
      rq_s3 <= rq_s2;
      if (go) begin
        run  <= 1'b1;
        rcnt <= '0;
      end else if (run) begin
        if (rcnt == RW'(RC_CNT - 1)) begin
          run     <= 1'b0;
          ack_tgl <= ~ack_tgl;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  // CPU domain: completion synchroniser
  logic ak_s1, ak_s2, ak_s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ak_s1 <= 1'b0;
      ak_s2 <= 1'b0;
      ak_s3 <= 1'b0;
    end else begin
      ak_s1 <= ack_tgl;
      ak_s2 <= ak_s1;
      ak_s3 <= ak_s2;
    end
  end

  assign ack_evt = ak_s2 ^ ak_s3;

  AST_RC_CNT_BOUND: assert property (@(posedge rc_clk) disable iff (!rst_n)
    run |-> (rcnt < RW'(RC_CNT))); // R10
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int CH_N = 4,
  parameter int DW   = 8
) (
  input  logic [CH_N*DW-1:0]       ain,
  input  logic [$clog2(CH_N)-1:0]  ch,
  output logic [DW-1:0]            sample
);
  assign sample = ain[ch*DW +: DW];
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int CPU_MC  = 31,
  parameter int SYNC_MC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_tick,
  input  logic start_req,
  input  logic rc_mode,
  input  logic ack_evt,
  output logic busy,
  output logic complete,
  output logic req_tgl
);
  localparam int CNT_MAX = (CPU_MC > SYNC_MC) ? CPU_MC : SYNC_MC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              launched;
  logic              pend;

  always_comb begin
    complete = 1'b0;
    if (state == SQ_CONV && mc_tick) begin
      if (!rc_mode) complete = (cnt == CNT_W'(CPU_MC - 1));
      else          complete = launched && (pend || ack_evt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      launched <= 1'b0;
      pend     <= 1'b0;
      req_tgl  <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start_req) begin
            state    <= SQ_CONV;
            cnt      <= '0;
            launched <= 1'b0;
            pend     <= 1'b0;
          end
        end
        SQ_CONV: begin
          if (complete) begin
            state <= SQ_FIN;
            pend  <= 1'b0;
          end else begin
            if (launched && ack_evt) pend <= 1'b1;
            if (mc_tick) begin
              if (!rc_mode) begin
                cnt <= cnt + 1'b1;
              end else if (!launched) begin
                if (cnt == CNT_W'(SYNC_MC - 1)) begin
                  launched <= 1'b1;
                  req_tgl  <= ~req_tgl;
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end
            end
          end
        end
        SQ_FIN: begin
          if (mc_tick) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy = (state != SQ_IDLE);

  AST_CPU_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_CONV && !rc_mode) |-> (cnt < CNT_W'(CPU_MC))); // R8
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> (state == SQ_IDLE)); // R4
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_N    = 4,
  parameter int DW      = 8,
  parameter int CPU_MC  = 31,
  parameter int SYNC_MC = 3,
  parameter int RC_CNT  = 108
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mc_tick,
  input  logic                 rc_clk,
  input  logic                 wr_en,
  input  logic [7:0]           wr_data,
  input  logic                 bit_wr_en,
  input  logic [2:0]           bit_idx,
  input  logic                 bit_val,
  input  logic [CH_N*DW-1:0]   ain,
  output logic [7:0]           ctrl_q,
  output logic                 irq,
  output logic [DW-1:0]        result
);
  localparam int CHW = $clog2(CH_N);

  logic           en_q, rc_q, done_q;
  logic [CHW-1:0] ch_q;
  logic [DW-1:0]  res_q;
  logic           busy, complete, req_tgl, ack_evt;
  logic [DW-1:0]  sample;

  // Unified write view: byte write wins over a single-bit write
  logic [7:0] wmask, wval;
  always_comb begin
    if (wr_en) begin
      wmask = 8'hFF;
      wval  = wr_data;
    end else if (bit_wr_en) begin
      wmask = 8'b1 << bit_idx;
      wval  = {8{bit_val}};
    end else begin
      wmask = 8'h00;
      wval  = 8'h00;
    end
  end

  logic           locked, en_n, rc_n, sw_clr, start_req;
  logic [CHW-1:0] ch_n;

  always_comb begin
    locked    = busy | done_q;
    en_n      = (wmask[B_EN] && (wval[B_EN] || !locked)) ? wval[B_EN] : en_q;
    rc_n      = (wmask[B_RC] && !locked) ? wval[B_RC] : rc_q;
    for (int i = 0; i < CHW; i++)
      ch_n[i] = (wmask[i] && !locked) ? wval[i] : ch_q[i];
    sw_clr    = wmask[B_DONE] && !wval[B_DONE];
    start_req = wmask[B_START] && wval[B_START] && !locked && en_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rc_q   <= 1'b0;
      ch_q   <= '0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      en_q   <= en_n;
      rc_q   <= rc_n;
      ch_q   <= ch_n;
      done_q <= complete | (done_q & ~sw_clr);
      if (complete) res_q <= sample;
    end
  end

  adc_seq_core #(.CPU_MC(CPU_MC), .SYNC_MC(SYNC_MC)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mc_tick   (mc_tick),
    .start_req (start_req),
    .rc_mode   (rc_q),
    .ack_evt   (ack_evt),
    .busy      (busy),
    .complete  (complete),
    .req_tgl   (req_tgl)
  );

  adc_rc_timer #(.RC_CNT(RC_CNT)) u_rc (
    .clk     (clk),
    .rc_clk  (rc_clk),
    .rst_n   (rst_n),
    .req_tgl (req_tgl),
    .ack_evt (ack_evt)
  );

  adc_conv_stub #(.CH_N(CH_N), .DW(DW)) u_stub (
    .ain    (ain),
    .ch     (ch_q),
    .sample (sample)
  );

  always_comb begin
    ctrl_q          = 8'h00;
    ctrl_q[B_EN]    = en_q;
    ctrl_q[B_DONE]  = done_q;
    ctrl_q[B_START] = busy;
    ctrl_q[B_RC]    = rc_q;
    ctrl_q[CHW-1:0] = ch_q;
  end
  assign irq    = done_q;
  assign result = res_q;

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !sw_clr) |=> done_q); // R5
  AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy || done_q) && en_q) |=> en_q); // R6
  AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done_q) |=> ($stable(rc_q) && $stable(ch_q))); // R7
  AST_FIN_ONE_MC: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done_q && !complete && mc_tick) |=> !busy); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !complete |=> $stable(res_q)); // R11
endmodule

// File: tb/adc_ctrl_seq_bench.sv
`timescale 1ns/1ps
module adc_ctrl_seq_bench;
  logic        clk = 1'b0;
  logic        rc_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mc_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        bit_wr_en = 1'b0;
  logic [2:0]  bit_idx = 3'd0;
  logic        bit_val = 1'b0;
  logic [31:0] ain = 32'hD49C5A13;
  logic [7:0]  ctrl_q;
  logic        irq;
  logic [7:0]  result;

  always #2.5 clk = ~clk;     // 200 MHz
  always #3.5 rc_clk = ~rc_clk;

  adc_ctrl_seq u_adc_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .rc_clk(rc_clk),
    .wr_en(wr_en), .wr_data(wr_data), .bit_wr_en(bit_wr_en),
    .bit_idx(bit_idx), .bit_val(bit_val), .ain(ain),
    .ctrl_q(ctrl_q), .irq(irq), .result(result)
  );

  int n_chk = 0;
  int n_bad = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // machine-cycle strobe every 4 clocks (20 ns)
  int div = 0;
  always @(negedge clk) begin
    div = (div + 1) % 4;
    mc_tick <= (div == 0);
  end

  // behavioural reference model
  bit       m_en, m_rc, m_done, m_rcwait;
  bit [1:0] m_ch;
  int       m_st;          // 0 idle, 1 converting, 2 finishing
  int       m_tcnt;
  bit [7:0] m_res;
  realtime  t_acc;
  bit       rc_hit = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_rc = 0; m_done = 0; m_ch = 0; m_st = 0;
      m_tcnt = 0; m_res = 0; m_rcwait = 0;
    end else begin
      bit [7:0] msk, val;
      bit lk, n_en, clr, hw, acc;
      msk = wr_en ? 8'hFF : (bit_wr_en ? (8'h01 << bit_idx) : 8'h00);
      val = wr_en ? wr_data : {8{bit_val}};
      lk  = (m_st != 0) || m_done;
      n_en = m_en;
      if (msk[7] && (val[7] || !lk)) n_en = val[7];
      clr = msk[4] && !val[4];
      acc = msk[3] && val[3] && !lk && n_en;
      hw = 0;
      if (m_st == 1 && !m_rc && mc_tick) begin
        m_tcnt++;
        if (m_tcnt == 31) begin hw = 1; m_res = ain[m_ch*8 +: 8]; m_st = 2; end
      end else if (m_st == 1 && m_rc) begin
        if (mc_tick) m_tcnt++;
        if (rc_hit) begin hw = 1; m_res = ain[m_ch*8 +: 8]; m_st = 2; m_rcwait = 0; end
      end else if (m_st == 2 && mc_tick) begin
        m_st = 0;
      end
      m_done = hw || (m_done && !clr);
      m_en = n_en;
      if (!lk) begin
        if (msk[2]) m_rc = val[2];
        if (msk[1]) m_ch[1] = val[1];
        if (msk[0]) m_ch[0] = val[0];
      end
      if (acc) begin
        m_st = 1; m_tcnt = 0; t_acc = $realtime; m_rcwait = m_rc;
      end
    end
  end

  // per-clock comparison
  bit prev_done = 0;
  bit late_flag = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      bit [7:0] e_ctrl, e_res;
      bit e_done;
      realtime el;
      el = $realtime - 2.5 - t_acc;
      rc_hit = m_rcwait && ctrl_q[4];
      e_done = m_done || rc_hit;
      e_ctrl = {m_en, 2'b00, e_done, (m_st != 0), m_rc, m_ch};
      e_res  = rc_hit ? ain[m_ch*8 +: 8] : m_res;
      check(ctrl_q == e_ctrl, "R2 R3 R4 R5 R6 R7 R9 ctrl per-clock", ctrl_q, e_ctrl);
      check(irq == e_done, "R5 irq per-clock", irq, e_done);
      check(result == e_res, "R11 result per-clock", result, e_res);
      if (ctrl_q[4] && !prev_done && m_st == 1 && !m_rc)
        check(m_tcnt == 31, "R8 ticks to done", m_tcnt, 31);
      if (rc_hit)
        check(el >= 796.0 && el <= 904.0, "R10 rc window ns", int'(el), 850);
      if (m_rcwait && el > 960.0 && !late_flag) begin
        late_flag = 1;
        check(0, "R10 rc done missing", 0, 1);
      end
      prev_done = ctrl_q[4];
    end
  end

  task automatic wr_byte(input logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic wr_bit(input int idx, input logic v);
    @(negedge clk); bit_wr_en = 1; bit_idx = idx[2:0]; bit_val = v;
    @(negedge clk); bit_wr_en = 0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic wait_done();
    for (int i = 0; i < 600; i++) begin
      if (ctrl_q[4]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #100000;
    check(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle(4);
    check(ctrl_q == 8'h00 && irq == 0 && result == 0, "R1 reset state", ctrl_q, 0);
    rst_n = 1;
    idle(2);
    // R2: reserved bits dropped, fields land in place
    wr_byte(8'h67);
    check(ctrl_q == 8'h07, "R2 reserved read 0", ctrl_q, 8'h07);
    // R12: start without enable
    wr_byte(8'h08);
    idle(6);
    check(ctrl_q[3] == 0, "R12 start ignored when disabled", ctrl_q, 0);
    // CPU conversion on channel 2
    wr_byte(8'h82);
    wr_bit(3, 1);
    check(ctrl_q == 8'h8A, "R3 start reads busy", ctrl_q, 8'h8A);
    idle(10);
    wr_byte(8'h01);
    check(ctrl_q == 8'h8A, "R6 R7 protected during busy", ctrl_q, 8'h8A);
    wr_bit(3, 1);
    check(ctrl_q[3] == 1, "R4 restart ignored", ctrl_q[3], 1);
    wait_done();
    check(ctrl_q == 8'h9A, "R9 start and done both set", ctrl_q, 8'h9A);
    check(irq == 1, "R5 irq raised", irq, 1);
    check(result == 8'h9C, "R11 result channel 2", result, 8'h9C);
    idle(5);
    check(ctrl_q == 8'h92, "R9 start cleared after one mc", ctrl_q, 8'h92);
    wr_bit(3, 1);
    idle(2);
    check(ctrl_q == 8'h92, "R4 start ignored while done", ctrl_q, 8'h92);
    wr_bit(4, 1);
    check(ctrl_q[4] == 1, "R5 write 1 to done no effect", ctrl_q[4], 1);
    wr_bit(4, 0);
    check(ctrl_q == 8'h82 && irq == 0, "R5 done cleared", ctrl_q, 8'h82);
    ain[23:16] = 8'h44;
    idle(4);
    check(result == 8'h9C, "R11 result held", result, 8'h9C);
    // RC conversion on channel 1
    wr_byte(8'h85);
    wr_bit(3, 1);
    wait_done();
    check(ctrl_q[4] == 1, "R10 rc conversion finished", ctrl_q[4], 1);
    check(result == 8'h5A, "R11 result channel 1", result, 8'h5A);
    wr_bit(4, 0);
    idle(6);
    wr_byte(8'h00);
    check(ctrl_q == 8'h00, "R6 enable clears when idle", ctrl_q, 0);
    // enable and start in one write, channel 0
    wr_byte(8'h88);
    check(ctrl_q[3] == 1, "R3 R12 start with enable same write", ctrl_q[3], 1);
    wait_done();
    check(result == 8'h13, "R11 result channel 0", result, 8'h13);
    idle(8);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule